// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Collision Arbitration

This block is a synchronous 2048-by-8 memory with two independent ports, left and right. Each port has its own active-low select, a read/write control (high reads, low writes), an active-low output enable, an 11-bit address, write data, read data and a read-data drive flag. The drive flag replaces a tri-state data bus. Either port can read or write any location on any cycle.

When both ports are selected at the same address, an arbiter grants the location to one port and raises busy on the other. The port that settled on that address and select earlier wins. The port that arrived later is busy. If both arrive on the same clock edge, the left port wins. A busy port's writes are suppressed inside the block, while its reads still return data. Its busy flag tells the reader that the data may be stale. A busy flag persists until the collision ends. A registered collision output (the OR of both busy indications) can serve as an interrupt.

A mode input selects the role of the block. In master mode it computes busy itself and drives the busy outputs. In slave mode it never raises busy. Instead, it takes each side's busy input as a write inhibit for that side. This lets several blocks in a wider array follow one master's decision.

Top module: `twin_port_ram`

## Requirements
- R1: A port with select low and read/write low writes its write data into the addressed location at the clock edge. With select low and read/write high, the read data shows the addressed byte after that edge. The drive flag is 1 after an edge only if select was low, read/write high and output enable low. Otherwise it is 0, which means high impedance.
- R2: Either port reaches all 2048 locations, including address 0x7FF. Data written by one port is read back by the other.
- R3: A busy output (active low) can go low only after an edge at which both selects were low and both addresses were equal. After any edge without that condition, both busy outputs are high. Both are high after reset.
- R4: Whether either colliding access is a read or a write does not change which port is made busy.
- R5: When one port has held its select and address unchanged since the previous edge and the other port has just arrived at the same address, the arriving port is made busy and the settled port is not.
- R6: When both ports arrive at the matching address on the same edge, including the first access after reset or after both were idle, the right port is made busy.
- R7: The two busy outputs are never low at the same time.
- R8: While the collision persists, the busy assignment is held even if both ports move together to another common address. Both busy outputs return high at the first edge after the collision ends.
- R9: A write from a port that is busy at that edge leaves memory unchanged. In master mode the busy input pins have no effect on writes.
- R10: A busy port that reads still receives the stored byte.
- R11: In slave mode both busy outputs stay high even during a collision. A low busy input blocks writes on its own side only.
- R12: After each edge, the collision output is 1 when a busy indication was active at that edge. In master mode that is the internal busy; in slave mode it is either busy input being low. Otherwise the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: arbitrate and drive busy outputs; 0: use busy inputs as write inhibits |
| l_sel_n | input | 1 | Left select, active low |
| l_rnw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_rdata_oe | output | 1 | Left read data is being driven |
| l_busy_n_o | output | 1 | Left busy, active low (master mode) |
| l_busy_n_i | input | 1 | Left write inhibit, active low (slave mode) |
| r_sel_n | input | 1 | Right select, active low |
| r_rnw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_rdata_oe | output | 1 | Right read data is being driven |
| r_busy_n_o | output | 1 | Right busy, active low (master mode) |
| r_busy_n_i | input | 1 | Right write inhibit, active low (slave mode) |
| collision | output | 1 | Registered OR of both busy indications |

## Verification
Every output of this block appears exactly one clock edge after the inputs that cause it. This applies to busy, collision, read data and the drive flag. The arbiter and the memory read are both registered at the edge that samples the port controls. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge, so each check sees the response to exactly one set of inputs. Suppressed writes are checked by reading the location back in a later cycle from the winning or opposite port. Arrival order is created by applying one port's select and address at least one edge before the other port's.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned DPR_ADDR_W = 11;
  localparam int unsigned DPR_DATA_W = 8;
  localparam int unsigned DPR_SIDES  = 2;
  // Side index used for every two-element vector in the block
  localparam int unsigned IDX_L = 0;
  localparam int unsigned IDX_R = 1;
endpackage

// File: rtl/dpr_collide_arb.sv
module dpr_collide_arb #(
  parameter int unsigned AW = dpr_pkg::DPR_ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master,
  input  logic [1:0]         sel_n,
  input  logic [1:0][AW-1:0] addr,
  output logic [1:0]         busy_nx,
  output logic [1:0]         busy_q
);
  import dpr_pkg::*;

  logic [1:0]         prev_sel_n;
  logic [1:0][AW-1:0] prev_addr;
  logic [1:0]         moved;
  logic               hit;

  // A side has "moved" if it was idle or on another address last edge
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      moved[s] = prev_sel_n[s] | (prev_addr[s] != addr[s]);
    end
  end

  assign hit = ~sel_n[IDX_L] & ~sel_n[IDX_R] & (addr[IDX_L] == addr[IDX_R]);

  always_comb begin
    busy_nx = '0;
    if (master && hit) begin
      if (|busy_q) begin
        busy_nx = busy_q;                       // hold while collision lasts
      end else if (moved[IDX_L] && !moved[IDX_R]) begin
        busy_nx[IDX_L] = 1'b1;                  // left came later
      end else begin
        busy_nx[IDX_R] = 1'b1;                  // right later, or tie
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= '0;
      prev_sel_n <= '1;
      prev_addr  <= '0;
    end else begin
      busy_q     <= busy_nx;
      prev_sel_n <= sel_n;
      prev_addr  <= addr;
    end
  end

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(busy_q[IDX_L] && busy_q[IDX_R])); // R7

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sel_n[IDX_L] || sel_n[IDX_R] || (addr[IDX_L] != addr[IDX_R])) |=> (busy_q == 2'b00)); // R3

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (master && (|busy_q) && !sel_n[IDX_L] && !sel_n[IDX_R] && (addr[IDX_L] == addr[IDX_R]))
      |=> (busy_q == $past(busy_q))); // R8

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master |=> (busy_q == 2'b00)); // R11
endmodule

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic rnw,
  input  logic oe_n,
  input  logic blocked,
  output logic wr_en,
  output logic rd_en,
  output logic drive_q
);
  assign wr_en = ~sel_n & ~rnw & ~blocked;
  assign rd_en = ~sel_n & rnw;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= ~sel_n & rnw & ~oe_n;
  end

  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !rnw) |=> !drive_q); // R1
endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int unsigned AW = dpr_pkg::DPR_ADDR_W,
  parameter int unsigned DW = dpr_pkg::DPR_DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         we,
  input  logic [1:0]         re,
  input  logic [1:0][AW-1:0] addr,
  input  logic [1:0][DW-1:0] wdata,
  output logic [1:0][DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we[0]) mem[addr[0]] <= wdata[0];
    if (we[1]) mem[addr[1]] <= wdata[1];
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (rst)        rd_q <= '0;
      else if (re[g]) rd_q <= mem[addr[g]];
    end
    assign rdata[g] = rd_q;
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int unsigned ADDR_W = dpr_pkg::DPR_ADDR_W,
  parameter int unsigned DATA_W = dpr_pkg::DPR_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_sel_n,
  input  logic              l_rnw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdata_oe,
  output logic              l_busy_n_o,
  input  logic              l_busy_n_i,
  input  logic              r_sel_n,
  input  logic              r_rnw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdata_oe,
  output logic              r_busy_n_o,
  input  logic              r_busy_n_i,
  output logic              collision
);
  import dpr_pkg::*;

  logic [1:0]             sel_n, rnw, oe_n, busy_n_i, blocked, we, re, drive_q;
  logic [1:0]             busy_nx, busy_q;
  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0][DATA_W-1:0] wdata, rdata;
  logic                   coll_q;

  assign sel_n    = {r_sel_n, l_sel_n};
  assign rnw      = {r_rnw, l_rnw};
  assign oe_n     = {r_oe_n, l_oe_n};
  assign busy_n_i = {r_busy_n_i, l_busy_n_i};
  assign addr     = {r_addr, l_addr};
  assign wdata    = {r_wdata, l_wdata};

  dpr_collide_arb #(.AW(ADDR_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .master  (master_mode),
    .sel_n   (sel_n),
    .addr    (addr),
    .busy_nx (busy_nx),
    .busy_q  (busy_q)
  );

  // Master trusts its own decision; slave obeys the pins
  assign blocked = master_mode ? busy_nx : ~busy_n_i;

  for (genvar g = 0; g < 2; g++) begin : g_port
    dpr_port_ctl u_ctl (
      .clk     (clk),
      .rst     (rst),
      .sel_n   (sel_n[g]),
      .rnw     (rnw[g]),
      .oe_n    (oe_n[g]),
      .blocked (blocked[g]),
      .wr_en   (we[g]),
      .rd_en   (re[g]),
      .drive_q (drive_q[g])
    );
  end

  dpr_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .re    (re),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) coll_q <= 1'b0;
    else     coll_q <= |blocked;
  end

  assign l_rdata    = rdata[IDX_L];
  assign r_rdata    = rdata[IDX_R];
  assign l_rdata_oe = drive_q[IDX_L];
  assign r_rdata_oe = drive_q[IDX_R];
  assign l_busy_n_o = ~busy_q[IDX_L];
  assign r_busy_n_o = ~busy_q[IDX_R];
  assign collision  = coll_q;

  AST_COLLISION_COVERS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n_o || !r_busy_n_o) |-> collision); // R12
endmodule

// File: tb/twin_port_ram_test.sv
`timescale 1ns/1ps
module twin_port_ram_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_mode = 1'b1;
  logic        l_sel_n = 1'b1, l_rnw = 1'b1, l_oe_n = 1'b0, l_busy_n_i = 1'b1;
  logic        r_sel_n = 1'b1, r_rnw = 1'b1, r_oe_n = 1'b0, r_busy_n_i = 1'b1;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_rdata_oe, r_rdata_oe, l_busy_n_o, r_busy_n_o, collision;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twin_port_ram uut (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_sel_n(l_sel_n), .l_rnw(l_rnw), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe),
    .l_busy_n_o(l_busy_n_o), .l_busy_n_i(l_busy_n_i),
    .r_sel_n(r_sel_n), .r_rnw(r_rnw), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe),
    .r_busy_n_o(r_busy_n_o), .r_busy_n_i(r_busy_n_i),
    .collision(collision)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One edge, then sample 1 ns later; exclusivity checked every cycle (R7)
  task automatic tick();
    @(posedge clk);
    #1;
    chk("R7", "busy exclusive", {31'd0, (!l_busy_n_o && !r_busy_n_o)}, 32'd0);
  endtask

  task automatic idle();
    l_sel_n = 1'b1; l_rnw = 1'b1; l_oe_n = 1'b0;
    r_sel_n = 1'b1; r_rnw = 1'b1; r_oe_n = 1'b0;
  endtask

  task automatic l_acc(input logic rnw, input logic [10:0] a, input logic [7:0] d);
    l_sel_n = 1'b0; l_rnw = rnw; l_oe_n = 1'b0; l_addr = a; l_wdata = d;
  endtask

  task automatic r_acc(input logic rnw, input logic [10:0] a, input logic [7:0] d);
    r_sel_n = 1'b0; r_rnw = rnw; r_oe_n = 1'b0; r_addr = a; r_wdata = d;
  endtask

  task automatic t_reset();
    chk("R3", "l busy after reset", l_busy_n_o, 1);
    chk("R3", "r busy after reset", r_busy_n_o, 1);
    chk("R12", "collision after reset", collision, 0);
    chk("R1", "l drive after reset", l_rdata_oe, 0);
  endtask

  task automatic t_basic();
    idle(); l_acc(1'b0, 11'h005, 8'hA5); tick();
    chk("R3", "no busy on lone access", l_busy_n_o, 1);
    idle(); r_acc(1'b1, 11'h005, 8'h00); tick();
    chk("R2", "right reads left data", r_rdata, 8'hA5);
    chk("R1", "drive during read", r_rdata_oe, 1);
    r_oe_n = 1'b1; tick();
    chk("R1", "no drive with oe high", r_rdata_oe, 0);
    idle(); r_acc(1'b0, 11'h7FF, 8'h5A); tick();
    chk("R1", "no drive on write", r_rdata_oe, 0);
    idle(); l_acc(1'b1, 11'h7FF, 8'h00); tick();
    chk("R2", "top address", l_rdata, 8'h5A);
  endtask

  task automatic t_right_late();
    idle(); l_acc(1'b0, 11'h100, 8'h11); tick();
    idle(); tick();
    l_acc(1'b1, 11'h100, 8'h00); tick();
    r_acc(1'b0, 11'h100, 8'h3C); tick();
    chk("R5", "late right busy", r_busy_n_o, 0);
    chk("R5", "early left free", l_busy_n_o, 1);
    chk("R12", "collision raised", collision, 1);
    r_rnw = 1'b1; tick();
    chk("R10", "busy right still reads", r_rdata, 8'h11);
    chk("R9", "right busy still held", r_busy_n_o, 0);
    l_sel_n = 1'b1; tick();
    chk("R8", "release right", r_busy_n_o, 1);
    chk("R12", "collision cleared", collision, 0);
  endtask

  task automatic t_left_late();
    idle(); r_acc(1'b0, 11'h200, 8'h22); tick();
    idle(); tick();
    r_acc(1'b1, 11'h200, 8'h00); tick();
    l_acc(1'b0, 11'h200, 8'hEE); tick();
    chk("R5", "late left busy", l_busy_n_o, 0);
    chk("R4", "reader right free", r_busy_n_o, 1);
    idle(); tick();
    r_acc(1'b1, 11'h200, 8'h00); tick();
    chk("R9", "left write blocked", r_rdata, 8'h22);
  endtask

  task automatic t_tie();
    idle(); tick();
    l_acc(1'b1, 11'h033, 8'h00); r_acc(1'b1, 11'h033, 8'h00); tick();
    chk("R6", "tie reads right busy", r_busy_n_o, 0);
    chk("R6", "tie reads left free", l_busy_n_o, 1);
    idle(); tick();
    l_acc(1'b0, 11'h033, 8'h44); r_acc(1'b0, 11'h033, 8'h55); tick();
    chk("R4", "tie writes right busy", r_busy_n_o, 0);
    idle(); tick();
    l_acc(1'b1, 11'h033, 8'h00); tick();
    chk("R9", "winner write kept", l_rdata, 8'h44);
  endtask

  task automatic t_hold();
    idle(); tick();
    r_acc(1'b1, 11'h044, 8'h00); tick();
    l_acc(1'b1, 11'h044, 8'h00); tick();
    chk("R5", "left busy before move", l_busy_n_o, 0);
    l_addr = 11'h045; r_addr = 11'h045; tick();
    chk("R8", "hold after joint move", l_busy_n_o, 0);
    chk("R8", "right stays free", r_busy_n_o, 1);
    tick();
    chk("R8", "hold steady", l_busy_n_o, 0);
    r_sel_n = 1'b1; tick();
    chk("R8", "release left", l_busy_n_o, 1);
    chk("R3", "no collision", collision, 0);
  endtask

  task automatic t_master_pins();
    idle(); l_busy_n_i = 1'b0; r_busy_n_i = 1'b0;
    l_acc(1'b0, 11'h300, 8'h99); tick();
    chk("R12", "master ignores pins", collision, 0);
    idle(); l_acc(1'b1, 11'h300, 8'h00); tick();
    chk("R9", "master write despite pin", l_rdata, 8'h99);
    l_busy_n_i = 1'b1; r_busy_n_i = 1'b1;
  endtask

  task automatic t_slave();
    idle(); master_mode = 1'b0; tick();
    l_acc(1'b1, 11'h400, 8'h00); r_acc(1'b0, 11'h400, 8'h66); tick();
    chk("R11", "slave no left busy", l_busy_n_o, 1);
    chk("R11", "slave no right busy", r_busy_n_o, 1);
    chk("R12", "slave no collision", collision, 0);
    idle(); l_busy_n_i = 1'b0; l_acc(1'b0, 11'h400, 8'h77); tick();
    chk("R12", "slave collision from pin", collision, 1);
    chk("R11", "slave outputs quiet", l_busy_n_o, 1);
    idle(); l_busy_n_i = 1'b1; r_busy_n_i = 1'b0; r_acc(1'b0, 11'h401, 8'h88); tick();
    idle(); r_busy_n_i = 1'b1; r_acc(1'b1, 11'h400, 8'h00); tick();
    chk("R11", "left inhibited", r_rdata, 8'h66);
    idle(); l_acc(1'b0, 11'h401, 8'h12); tick();
    idle(); r_acc(1'b1, 11'h401, 8'h00); tick();
    chk("R11", "inhibit cleared", r_rdata, 8'h12);
    idle(); master_mode = 1'b1; tick();
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_basic();
    t_right_late();
    t_left_late();
    t_tie();
    t_hold();
    t_master_pins();
    t_slave();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule